// File: doc/BRIEF.md
# Indirect double-buffered PLL configuration port

This block is the host-facing register file for the coefficient registers of two clock synthesizers: a system PLL and an audio PLL. Each PLL owns a staging bank, which the host can reach, and an active bank, which drives the PLL's coefficient inputs. The host cannot address a coefficient directly. It loads a byte-wide data register and an indirect address register over a simple address/data bus, then writes a command register that performs the access or commits a staging bank into its active bank.

One command write can read one staging register into the data register, store the data register into one staging register, and commit either or both PLLs. The command acts once and its action fields clear themselves. The active coefficients change only on a commit, so the host can reprogram a complete set without the PLL ever seeing a partial set. A separate audio enable bit also sits on the bus. It clears on hardware reset and sets on software reset.

Top module: `pll_cfg_port`

## Requirements
- R1: After the asynchronous active-low reset, the data (0x11), indirect address (0x12), command (0x1D) and audio enable (0xB5) registers read 0, and both active banks and `au_en_o` are 0.
- R2: Bus reads return the written value at 0x11 and 0x12 in the same cycle as `addr_i` is presented. Any bus address that is not mapped reads 0.
- R3: A command write with bits [1:0] = 01 copies the staging register selected by the indirect address into the data register. The new value is readable at 0x11 from the next cycle.
- R4: A command write with bits [1:0] = 10 stores the data register into the selected staging register. The active banks are not changed by it.
- R5: A command write with bit 2 set copies the whole system staging bank into `sys_bank_o`, visible from the next cycle. With bit 2 clear, `sys_bank_o` holds its value.
- R6: A command write with bit 3 set copies the whole audio staging bank into `au_bank_o`, visible from the next cycle. With bit 3 clear, `au_bank_o` holds its value.
- R7: The indirect addresses are: system 2 disable, 3 fraction low, 4 fraction high, 6 N, 7 X, 8 M, 9 update; audio 10 disable, 11 fraction low, 12 fraction high, 14 N, 15 X, 16 M, 17 update. In each bank output, byte k (bits 8k+7..8k) holds, for k = 0..6, the disable, fraction low, fraction high, N, X, M and update registers.
- R8: A write access to an indirect address outside the R7 set changes nothing, and a read access to such an address loads 0 into the data register.
- R9: Access code 11 is ignored: it leaves both the data register and the staging registers unchanged. Access code 00 performs no access.
- R10: Command bits [3:0] clear after the write in which they act, so they always read 0. Bits [7:4] read back as last written.
- R11: When a single command write holds both a write access and a commit bit, the commit carries the value just written.
- R12: Bit 0 of 0xB5 is the audio enable `au_en_o`, and it reads back at bit 0 with bits [7:1] reading 0. A cycle with `soft_rst_i` high sets it to 1 from the next cycle and takes priority over a bus write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| soft_rst_i | input | 1 | Synchronous software reset strobe |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 8 | Bus address |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data for `addr_i`, combinational |
| sys_bank_o | output | 56 | System PLL active coefficients, layout per R7 |
| au_bank_o | output | 56 | Audio PLL active coefficients, layout per R7 |
| au_en_o | output | 1 | Audio PLL enable |

## Verification
The assertions assume that the bus carries at most one write per cycle. They also assume that every command write and its effects are seen on the clock edge that follows, with reset high throughout. The bench drives every write at a falling edge and holds it for exactly one cycle, and it samples `rdata_o` between edges. The commit-hold properties assume that a bank output can change only through a command write with that PLL's commit bit set. The stimulus includes command writes that carry no commit bit, so those properties are exercised.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam int NSLOT  = 7;
  localparam int NPLL   = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_BAD   = 2'b11
  } acc_e;

  // {hit, slot}: offsets 0..2 -> slots 0..2, offset 3 is a hole, 4..7 -> 3..6
  function automatic logic [3:0] slot_of(input logic [AW-1:0] addr,
                                         input logic [AW-1:0] base);
    logic [AW-1:0] off;
    off = addr - base;
    case (off)
      8'd0, 8'd1, 8'd2:        slot_of = {1'b1, off[2:0]};
      8'd4, 8'd5, 8'd6, 8'd7:  slot_of = {1'b1, off[2:0] - 3'd1};
      default:                 slot_of = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/pll_cfg_host_regs.sv
module pll_cfg_host_regs
  import pll_cfg_pkg::*;
#(
  parameter int            DATA_W    = DW,
  parameter int            ADDR_W    = AW,
  parameter int            N_PLL     = NPLL,
  parameter logic [ADDR_W-1:0] ADDR_DATA = 8'h11,
  parameter logic [ADDR_W-1:0] ADDR_IND  = 8'h12,
  parameter logic [ADDR_W-1:0] ADDR_CMD  = 8'h1D,
  parameter logic [ADDR_W-1:0] ADDR_EN   = 8'hB5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] stg_rdata_i,
  output logic [DATA_W-1:0] data_q_o,
  output logic [ADDR_W-1:0] ind_q_o,
  output acc_e              acc_o,
  output logic [N_PLL-1:0]  xfer_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              au_en_o
);
  localparam int LO_W = 2 + N_PLL;
  localparam int HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] ind_q;
  logic [HI_W-1:0]   cmd_hi_q;
  logic              en_q;
  logic              cmd_wr;

  assign cmd_wr = wr_en_i && (addr_i == ADDR_CMD);
  assign acc_o  = cmd_wr ? acc_e'(wdata_i[1:0]) : ACC_NONE;
  assign xfer_o = cmd_wr ? wdata_i[LO_W-1:2] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      ind_q    <= '0;
      cmd_hi_q <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_DATA) data_q <= wdata_i;
      else if (acc_o == ACC_READ)         data_q <= stg_rdata_i;
      if (wr_en_i && addr_i == ADDR_IND)  ind_q <= wdata_i;
      if (cmd_wr)                         cmd_hi_q <= wdata_i[DATA_W-1:LO_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             en_q <= 1'b0;
    else if (soft_rst_i)                     en_q <= 1'b1;
    else if (wr_en_i && addr_i == ADDR_EN)   en_q <= wdata_i[0];
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_o = data_q;
      ADDR_IND:  rdata_o = ind_q;
      ADDR_CMD:  rdata_o = {cmd_hi_q, {LO_W{1'b0}}};
      ADDR_EN:   rdata_o = {{(DATA_W-1){1'b0}}, en_q};
      default:   rdata_o = '0;
    endcase
  end

  assign data_q_o = data_q;
  assign ind_q_o  = ind_q;
  assign au_en_o  = en_q;
endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
  import pll_cfg_pkg::*;
#(
  parameter int              DATA_W = DW,
  parameter int              ADDR_W = AW,
  parameter int              N_SLOT = NSLOT,
  parameter logic [ADDR_W-1:0] BASE = 8'd2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic                     xfer_i,
  input  logic [ADDR_W-1:0]        ind_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [N_SLOT*DATA_W-1:0] active_o
);
  logic [3:0]        hit;
  logic [DATA_W-1:0] stg [N_SLOT];

  assign hit = slot_of(ind_i, BASE);

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    logic sel;
    logic [DATA_W-1:0] stg_nxt;
    logic [DATA_W-1:0] act_q;

    assign sel     = wr_i && hit[3] && (hit[2:0] == 3'(k));
    assign stg_nxt = sel ? wdata_i : stg[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg[k] <= '0;
        act_q  <= '0;
      end else begin
        stg[k] <= stg_nxt;
        if (xfer_i) act_q <= stg_nxt;  // same-cycle write is committed
      end
    end

    assign active_o[k*DATA_W +: DATA_W] = act_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_SLOT; k++)
      if (hit[3] && hit[2:0] == 3'(k)) rdata_o = stg[k];
  end
endmodule

// File: rtl/pll_cfg_port.sv
module pll_cfg_port
  import pll_cfg_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW,
  parameter int N_SLOT = NSLOT,
  parameter logic [2*ADDR_W-1:0] BASES = {8'd10, 8'd2},
  localparam int BANK_W = N_SLOT * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [BANK_W-1:0] sys_bank_o,
  output logic [BANK_W-1:0] au_bank_o,
  output logic              au_en_o
);
  localparam int N_PLL = 2;

  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] ind_q;
  acc_e              acc;
  logic [N_PLL-1:0]  xfer;
  logic [DATA_W-1:0] stg_rdata;
  logic [DATA_W-1:0] bank_rd [N_PLL];
  logic [BANK_W-1:0] bank_act [N_PLL];

  pll_cfg_host_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_PLL(N_PLL)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .stg_rdata_i(stg_rdata),
    .data_q_o   (data_q),
    .ind_q_o    (ind_q),
    .acc_o      (acc),
    .xfer_o     (xfer),
    .rdata_o    (rdata_o),
    .au_en_o    (au_en_o)
  );

  for (genvar i = 0; i < N_PLL; i++) begin : g_pll
    pll_cfg_bank #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_SLOT(N_SLOT),
      .BASE(BASES[i*ADDR_W +: ADDR_W])
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (acc == ACC_WRITE),
      .xfer_i  (xfer[i]),
      .ind_i   (ind_q),
      .wdata_i (data_q),
      .rdata_o (bank_rd[i]),
      .active_o(bank_act[i])
    );
  end

  // banks decode disjoint ranges, so at most one is non-zero
  always_comb begin
    stg_rdata = '0;
    for (int i = 0; i < N_PLL; i++) stg_rdata = stg_rdata | bank_rd[i];
  end

  assign sys_bank_o = bank_act[0];
  assign au_bank_o  = bank_act[1];
endmodule

// File: rtl/pll_cfg_port_chk.sv
module pll_cfg_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        soft_rst_i,
  input logic        wr_en_i,
  input logic [7:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic [55:0] sys_bank_o,
  input logic [55:0] au_bank_o,
  input logic        au_en_o,
  input logic [7:0]  data_q,
  input logic [7:0]  ind_q
);
  logic cmd_wr;
  logic ind_known;
  assign cmd_wr = wr_en_i && addr_i == 8'h1D;
  assign ind_known = (ind_q >= 8'd2 && ind_q <= 8'd17) && ind_q != 8'd5 && ind_q != 8'd13;

  AST_SYS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_wr && wdata_i[2]) |=> $stable(sys_bank_o)); // R5
  AST_AU_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_wr && wdata_i[3]) |=> $stable(au_bank_o)); // R6
  AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[1:0] == 2'b01 && !ind_known) |=> data_q == 8'h00); // R8
  AST_BAD_ACC_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[1:0] == 2'b11) |=> $stable(data_q)); // R9
  AST_CMD_LO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h1D) |-> rdata_o[3:0] == 4'h0); // R10
  AST_WR_BEFORE_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[2:0] == 3'b110 && ind_q == 8'd3) |=> sys_bank_o[15:8] == $past(data_q)); // R11
  AST_SOFT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> au_en_o); // R12
endmodule

bind pll_cfg_port pll_cfg_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .sys_bank_o(sys_bank_o),
  .au_bank_o(au_bank_o), .au_en_o(au_en_o), .data_q(data_q), .ind_q(ind_q)
);

// File: tb/pll_cfg_port_tb.sv
module pll_cfg_port_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;
  logic [55:0] sys_bank_o;
  logic [55:0] au_bank_o;
  logic        au_en_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] stg [2][7];
  logic [7:0] rd;

  always #5 clk = ~clk;

  pll_cfg_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sys_bank_o(sys_bank_o), .au_bank_o(au_bank_o), .au_en_o(au_en_o)
  );

  // {indirect address, data, expected read-back}
  localparam logic [23:0] TBL [19] = '{
    {8'd3,  8'h11, 8'h11}, {8'd4,  8'h22, 8'h22}, {8'd6,  8'h33, 8'h33},
    {8'd7,  8'h44, 8'h44}, {8'd8,  8'h55, 8'h55}, {8'd9,  8'h66, 8'h66},
    {8'd2,  8'h77, 8'h77}, {8'd11, 8'h81, 8'h81}, {8'd12, 8'h92, 8'h92},
    {8'd14, 8'hA3, 8'hA3}, {8'd15, 8'hB4, 8'hB4}, {8'd16, 8'hC5, 8'hC5},
    {8'd17, 8'hD6, 8'hD6}, {8'd10, 8'hE7, 8'hE7}, {8'd5,  8'h5A, 8'h00},
    {8'd13, 8'h5B, 8'h00}, {8'd1,  8'h5C, 8'h00}, {8'd18, 8'h5D, 8'h00},
    {8'hFF, 8'h5E, 8'h00}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    addr_i = a;
    #2;
    d = rdata_o;
  endtask

  // map per R7: returns {hit, pll, slot}
  function automatic logic [4:0] tb_map(input logic [7:0] a);
    case (a)
      8'd2: tb_map = {1'b1, 1'b0, 3'd0};  8'd3: tb_map = {1'b1, 1'b0, 3'd1};
      8'd4: tb_map = {1'b1, 1'b0, 3'd2};  8'd6: tb_map = {1'b1, 1'b0, 3'd3};
      8'd7: tb_map = {1'b1, 1'b0, 3'd4};  8'd8: tb_map = {1'b1, 1'b0, 3'd5};
      8'd9: tb_map = {1'b1, 1'b0, 3'd6};  8'd10: tb_map = {1'b1, 1'b1, 3'd0};
      8'd11: tb_map = {1'b1, 1'b1, 3'd1}; 8'd12: tb_map = {1'b1, 1'b1, 3'd2};
      8'd14: tb_map = {1'b1, 1'b1, 3'd3}; 8'd15: tb_map = {1'b1, 1'b1, 3'd4};
      8'd16: tb_map = {1'b1, 1'b1, 3'd5}; 8'd17: tb_map = {1'b1, 1'b1, 3'd6};
      default: tb_map = 5'd0;
    endcase
  endfunction

  function automatic logic [55:0] bank_of(input int p);
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[k*8 +: 8] = stg[p][k];
    return v;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) for (int k = 0; k < 7; k++) stg[p][k] = 8'h00;
    #23 rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(8'h11, rd); chk("R1 data", rd, 0);
    bus_rd(8'h12, rd); chk("R1 ind", rd, 0);
    bus_rd(8'h1D, rd); chk("R1 cmd", rd, 0);
    bus_rd(8'hB5, rd); chk("R1 en", rd, 0);
    chk("R1 banks", {sys_bank_o, au_bank_o, au_en_o}, 0);

    // R2 direct register readback
    bus_wr(8'h11, 8'hA5); bus_rd(8'h11, rd); chk("R2 data", rd, 8'hA5);
    bus_wr(8'h12, 8'h3C); bus_rd(8'h12, rd); chk("R2 ind", rd, 8'h3C);
    bus_wr(8'h40, 8'hFF); bus_rd(8'h40, rd); chk("R2 unmapped", rd, 0);

    // R3 R4 R7 R8 table walk: write access then read access
    for (int i = 0; i < 19; i++) begin
      logic [4:0] m;
      m = tb_map(TBL[i][23:16]);
      bus_wr(8'h11, TBL[i][15:8]);
      bus_wr(8'h12, TBL[i][23:16]);
      bus_wr(8'h1D, 8'h02);
      if (m[4]) stg[m[3]][m[2:0]] = TBL[i][15:8];
      bus_wr(8'h11, 8'hEE);
      bus_wr(8'h1D, 8'h01);
      bus_rd(8'h11, rd);
      chk(m[4] ? "R3 R4 R7 readback" : "R8 unmapped readback", rd, TBL[i][7:0]);
    end

    // R4 active banks untouched by staging writes
    chk("R4 sys idle", sys_bank_o, 0);
    chk("R4 au idle", au_bank_o, 0);

    // R5 system commit only
    bus_wr(8'h1D, 8'h04);
    chk("R5 R7 sys commit", sys_bank_o, bank_of(0));
    chk("R5 sys layout", sys_bank_o, 56'h66_55_44_33_22_11_77);
    chk("R6 au held", au_bank_o, 0);

    // R6 audio commit
    bus_wr(8'h1D, 8'h08);
    chk("R6 R7 au commit", au_bank_o, 56'hD6_C5_B4_A3_92_81_E7);

    // R11 write then commit in one command
    bus_wr(8'h11, 8'h99); bus_wr(8'h12, 8'd3);
    bus_wr(8'h1D, 8'h06); stg[0][1] = 8'h99;
    chk("R11 combined", sys_bank_o, bank_of(0));

    // R9 forbidden and null access codes
    bus_wr(8'h11, 8'h42);
    bus_wr(8'h1D, 8'h03); bus_rd(8'h11, rd); chk("R9 code11 data", rd, 8'h42);
    bus_wr(8'h1D, 8'h00); bus_rd(8'h11, rd); chk("R9 code00 data", rd, 8'h42);
    bus_wr(8'h1D, 8'h01); bus_rd(8'h11, rd); chk("R9 staging kept", rd, 8'h99);

    // R10 self-clearing command fields
    bus_wr(8'h1D, 8'hF1); bus_rd(8'h1D, rd); chk("R10 cmd read", rd, 8'hF0);

    // R12 audio enable
    bus_wr(8'hB5, 8'hFF); bus_rd(8'hB5, rd); chk("R12 en read", rd, 8'h01);
    chk("R12 en out", au_en_o, 1);
    bus_wr(8'hB5, 8'h00); chk("R12 en clear", au_en_o, 0);
    @(negedge clk); soft_rst_i = 1'b1; wr_en_i = 1'b1; addr_i = 8'hB5; wdata_i = 8'h00;
    @(negedge clk); soft_rst_i = 1'b0; wr_en_i = 1'b0;
    chk("R12 soft set", au_en_o, 1);

    // R1 hard reset mid-run
    rst_ni = 1'b0; #3;
    chk("R1 rerun", {sys_bank_o, au_bank_o, au_en_o}, 0);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule